// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block caches recently used virtual-to-physical page mappings. It holds 64 entries, and a translation may sit in any of them. The lookup side is purely combinational. A virtual address and an access kind come in. In the same cycle the block reports whether the page is present, the physical address, and whether the stored permissions forbid this access. On a miss, an external page-table walker later installs the missing mapping through the fill side. The block chooses the slot itself.

Each slot keeps a tag, a physical page number, permission bits, a valid flag, a reference flag and a modified flag. The reference flags drive a clock-hand approximation of least-recently-used replacement. When a filled mapping pushes out a live one, the block reports the displaced page and its modified flag in that same cycle. The surrounding logic can then schedule a write-back. A flush input empties the whole cache in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After synchronous reset every slot is empty. Every lookup misses, and no eviction is reported.
- R2: A lookup hits only when its virtual page number (address bits 31:12) equals the tag of a slot whose valid flag is set. `lk_hit` rises in the same cycle. `lk_paddr` is then the stored physical page number followed by the unchanged 12-bit offset, and it is zero on a miss.
- R3: The permission field has read in bit 0, write in bit 1 and execute in bit 2. Access kind 1 (store) needs write, kind 2 (fetch) needs execute, and kinds 0 and 3 need read. A hit that lacks the needed bit raises `lk_fault` while `lk_hit` stays high. `lk_fault` is never high without `lk_hit`.
- R4: A lookup hit sets that slot's reference flag. A permitted store hit also sets its modified flag. A faulting store leaves the modified flag unchanged.
- R5: A fill whose page is absent goes to the lowest-numbered empty slot when any slot is empty. The replacement hand does not move in that case.
- R6: When all slots are valid, the hand scans upward from its position with wrap-around. It clears each set reference flag it passes and picks the first slot whose flag is clear. If every flag is set, it clears all of them and picks the slot it started at. The hand then moves to the slot after the victim.
- R7: A fill that replaces a valid slot raises `evict_valid` in the fill cycle, with the displaced page number on `evict_vpn` and its modified flag on `evict_dirty`.
- R8: A fill whose page is already present rewrites that slot's physical page number and permissions and keeps its modified flag. It creates no second copy and reports no eviction.
- R9: `flush` empties every slot in one cycle. A fill in the same cycle is dropped.
- R10: A newly installed slot starts with its reference flag set and its modified flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_hit | output | 1 | Mapping found |
| lk_fault | output | 1 | Mapping found but the access is not permitted |
| lk_paddr | output | 32 | Translated physical address |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rights | input | 3 | Permissions {exec, write, read} |
| flush | input | 1 | Empty all slots |
| evict_valid | output | 1 | A valid slot is being replaced this cycle |
| evict_vpn | output | 20 | Page number of the displaced slot |
| evict_dirty | output | 1 | Displaced slot had been modified |

## Verification
The bench first fills the cache from empty. This shows lowest-slot placement apart from clock replacement. It then sends loads, stores and fetches against read-write pages and read-execute pages, so that permitted hits, faulting hits and misses can be told apart. Stores before eviction show whether modified flags are reported. A fill of a present page separates an overwrite from a duplicate install. A flush followed by lookups tests that a single cycle empties the cache. A long random run then draws page numbers from a pool a little larger than the cache, mixing hits, refills, clock sweeps and the occasional flush. All outputs in that run are compared against a bench model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int RIGHTS_W = 3;

    typedef struct packed {
        logic x;   // bit 2: execute
        logic w;   // bit 1: write
        logic r;   // bit 0: read
    } rights_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_e;

    function automatic logic access_ok(rights_t rt, acc_e kind);
        case (kind)
            ACC_STORE: return rt.w;
            ACC_FETCH: return rt.x;
            default:   return rt.r;
        endcase
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N    = 64,
    parameter int TW   = 20,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [TW-1:0] tags [N],
    input  logic [TW-1:0] key,
    output logic [N-1:0]  hit_vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign any = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N   = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  refd,
    input  logic [IW-1:0] hand,
    output logic [IW-1:0] victim,
    output logic          use_clock,
    output logic [N-1:0]  clr_mask
);
    logic [IW-1:0] free_idx;
    logic [IW-1:0] clk_idx;

    assign use_clock = &valid;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IW'(i);
        end
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        clk_idx  = hand;
        clr_mask = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(hand) + i) % N;
            if (!found) begin
                if (!refd[j]) begin
                    found   = 1'b1;
                    clk_idx = IW'(j);
                end else begin
                    clr_mask[j] = 1'b1;
                end
            end
        end
    end

    assign victim = use_clock ? clk_idx : free_idx;
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [1:0]          lk_kind,
    output logic                lk_hit,
    output logic                lk_fault,
    output logic [PA_W-1:0]     lk_paddr,
    input  logic                fill_valid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    input  logic                flush,
    output logic                evict_valid,
    output logic [VPN_W-1:0]    evict_vpn,
    output logic                evict_dirty
);
    logic [ENTRIES-1:0] valid_q, ref_q, dirty_q;
    logic [ENTRIES-1:0] valid_n, ref_n, dirty_n;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    rights_t            rights_q[ENTRIES];
    logic [IDX_W-1:0]   hand_q, hand_n;

    // lookup side
    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] hit_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_ok;
    acc_e               kind;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign kind   = acc_e'(lk_kind);

    tlb_match #(.N(ENTRIES), .TW(VPN_W)) u_lk_match (
        .valid(valid_q), .tags(vpn_q), .key(lk_vpn),
        .hit_vec(hit_vec), .any(lk_any), .idx(lk_idx)
    );

    assign lk_ok    = access_ok(rights_q[lk_idx], kind);
    assign lk_hit   = lk_valid && lk_any;
    assign lk_fault = lk_hit && !lk_ok;
    assign lk_paddr = lk_hit ? {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;

    // fill side
    logic [ENTRIES-1:0] fill_hit_vec;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   victim;
    logic               use_clock;
    logic [ENTRIES-1:0] clr_mask;
    logic               fill_do;
    logic               fill_new;
    logic [IDX_W-1:0]   wr_idx;

    tlb_match #(.N(ENTRIES), .TW(VPN_W)) u_fill_match (
        .valid(valid_q), .tags(vpn_q), .key(fill_vpn),
        .hit_vec(fill_hit_vec), .any(fill_any), .idx(fill_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid(valid_q), .refd(ref_q), .hand(hand_q),
        .victim(victim), .use_clock(use_clock), .clr_mask(clr_mask)
    );

    assign fill_do  = fill_valid && !flush;
    assign fill_new = fill_do && !fill_any;
    assign wr_idx   = fill_any ? fill_idx : victim;

    assign evict_valid = fill_new && valid_q[victim];
    assign evict_vpn   = evict_valid ? vpn_q[victim] : '0;
    assign evict_dirty = evict_valid && dirty_q[victim];

    always_comb begin
        valid_n = valid_q;
        ref_n   = ref_q;
        dirty_n = dirty_q;
        hand_n  = hand_q;
        if (fill_new && use_clock) begin
            ref_n  = ref_n & ~clr_mask;
            hand_n = (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
        if (lk_hit) begin
            ref_n[lk_idx] = 1'b1;
            if (kind == ACC_STORE && lk_ok) dirty_n[lk_idx] = 1'b1;
        end
        if (fill_do) begin
            ref_n[wr_idx] = 1'b1;
            if (!fill_any) begin
                valid_n[wr_idx] = 1'b1;
                dirty_n[wr_idx] = 1'b0;
            end
        end
        if (flush) valid_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ref_q   <= '0;
            dirty_q <= '0;
            hand_q  <= '0;
        end else begin
            valid_q <= valid_n;
            ref_q   <= ref_n;
            dirty_q <= dirty_n;
            hand_q  <= hand_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && fill_do) begin
            vpn_q[wr_idx]    <= fill_vpn;
            ppn_q[wr_idx]    <= fill_ppn;
            rights_q[wr_idx] <= rights_t'(fill_rights);
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_hit,
    input logic         lk_fault,
    input logic         fill_valid,
    input logic         flush,
    input logic         evict_valid,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] fill_hit_vec
);
    // R3
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);

    // R7
    evict_only_on_fill_chk: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (fill_valid && !flush));

    // R8
    no_evict_on_rewrite_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && |fill_hit_vec) |-> !evict_valid);

    // R8
    single_copy_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec) && $onehot0(fill_hit_vec));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);
endmodule

bind tlb_fa tlb_fa_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .fill_valid(fill_valid), .flush(flush), .evict_valid(evict_valid),
    .hit_vec(hit_vec), .fill_hit_vec(fill_hit_vec)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic        lk_hit, lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_ppn;
    logic [2:0]  fill_rights;
    logic        flush;
    logic        evict_valid;
    logic [19:0] evict_vpn;
    logic        evict_dirty;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit        m_valid [N];
    bit        m_ref   [N];
    bit        m_dirty [N];
    bit [19:0] m_vpn   [N];
    bit [19:0] m_ppn   [N];
    bit [2:0]  m_rt    [N];
    int        m_hand;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_rights(fill_rights), .flush(flush),
        .evict_valid(evict_valid), .evict_vpn(evict_vpn),
        .evict_dirty(evict_dirty)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit perm(bit [2:0] rt, bit [1:0] k);
        if (k == 2'd1) return rt[1];
        if (k == 2'd2) return rt[2];
        return rt[0];
    endfunction

    function automatic int find(bit [19:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
        end
        m_hand = 0;
    endfunction

    // one cycle: drive, check combinational outputs, update model
    task automatic step(string tag, bit lv, bit [31:0] va, bit [1:0] k,
                        bit fv, bit [19:0] fvpn, bit [19:0] fppn,
                        bit [2:0] fr, bit fl);
        int  h, fm, vic;
        bit  all_valid, ok, e_ev;
        bit  clr [N];
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_kind = k;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_rights = fr;
        flush = fl;
        #1;
        h  = lv ? find(va[31:12]) : -1;
        ok = (h >= 0) ? perm(m_rt[h], k) : 1'b0;
        // R2
        chk({tag, " R2 hit"}, lk_hit, h >= 0);
        chk({tag, " R2 paddr"}, lk_paddr, (h >= 0) ? {m_ppn[h], va[11:0]} : 32'h0);
        // R3
        chk({tag, " R3 fault"}, lk_fault, (h >= 0) && !ok);
        fm = find(fvpn);
        all_valid = 1;
        for (int i = 0; i < N; i++) begin
            all_valid &= m_valid[i];
            clr[i] = 0;
        end
        vic = 0;
        if (!all_valid) begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) vic = i;
        end else begin
            bit found = 0;
            vic = m_hand;
            for (int i = 0; i < N; i++) begin
                int j = (m_hand + i) % N;
                if (!found) begin
                    if (!m_ref[j]) begin found = 1; vic = j; end
                    else clr[j] = 1;
                end
            end
        end
        e_ev = fv && !fl && fm < 0 && all_valid;
        // R7
        chk({tag, " R7 evict_valid"}, evict_valid, e_ev);
        if (e_ev) begin
            chk({tag, " R7 evict_vpn"}, evict_vpn, m_vpn[vic]);
            chk({tag, " R7 evict_dirty"}, evict_dirty, m_dirty[vic]);
        end
        // model update in the order the requirements define
        if (fv && !fl && fm < 0 && all_valid) begin
            for (int i = 0; i < N; i++) if (clr[i]) m_ref[i] = 0;
            m_hand = (vic + 1) % N;
        end
        if (h >= 0) begin
            m_ref[h] = 1;
            if (k == 2'd1 && ok) m_dirty[h] = 1;
        end
        if (fv && !fl) begin
            int w = (fm >= 0) ? fm : vic;
            m_ref[w] = 1; m_ppn[w] = fppn; m_rt[w] = fr; m_vpn[w] = fvpn;
            if (fm < 0) begin m_valid[w] = 1; m_dirty[w] = 0; end
        end
        if (fl) for (int i = 0; i < N; i++) m_valid[i] = 0;
    endtask

    task automatic look(string tag, bit [19:0] v, bit [1:0] k);
        step(tag, 1, {v, 12'h5a4}, k, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(string tag, bit [19:0] v, bit [19:0] p, bit [2:0] r);
        step(tag, 0, 0, 0, 1, v, p, r, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1d5e));
        rst = 1; lk_valid = 0; lk_vaddr = 0; lk_kind = 0;
        fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_rights = 0; flush = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: empty after reset
        look("R1 reset", 20'h0, 0);
        look("R1 reset", 20'h10, 0);

        // R5 R10: fill from empty into lowest free slots
        for (int i = 0; i < N; i++)
            fill("R5 fill", 20'(i + 10), 20'(i + 20'h300), (i % 2 == 0) ? 3'b011 : 3'b101);
        for (int i = 0; i < N; i++) look("R2 look", 20'(i + 10), 2'd0);

        // R3 R4: faults and permitted stores
        look("R3 store ro", 20'd11, 2'd1);
        look("R3 fetch rw", 20'd10, 2'd2);
        look("R3 fetch rx", 20'd11, 2'd2);
        look("R4 store rw", 20'd10, 2'd1);
        look("R4 store rw", 20'd14, 2'd1);

        // R6 R7: all referenced, hand at 0 -> clears all, victim slot 0 (dirty)
        fill("R6 clock", 20'd500, 20'h777, 3'b111);
        chk("R6 evicted slot0", 1, find(20'd10) < 0);
        // next victim is slot 1 (clean, ref cleared)
        fill("R6 clock2", 20'd501, 20'h778, 3'b111);
        chk("R6 evicted slot1", 1, find(20'd11) < 0);
        look("R4 keep", 20'd12, 2'd0);

        // R8: rewrite existing page
        fill("R8 rewrite", 20'd14, 20'h999, 3'b001);
        look("R8 look", 20'd14, 2'd0);
        look("R8 ro store", 20'd14, 2'd1);

        // R9: flush, and flush with simultaneous fill
        step("R9 flush", 1, {20'd14, 12'h0}, 0, 1, 20'd600, 20'h1, 3'b111, 1);
        look("R9 after", 20'd14, 0);
        look("R9 dropped", 20'd600, 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit [19:0] v = 20'($urandom_range(0, 79));
            bit [19:0] fvp = 20'($urandom_range(0, 79));
            bit fv = ($urandom_range(0, 99) < 35);
            bit fl = ($urandom_range(0, 999) < 4);
            step("RND", $urandom_range(0, 9) < 8, {v, 12'($urandom)},
                 2'($urandom), fv, fvp, 20'($urandom), 3'($urandom), fl);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule